// File: doc/BRIEF.md
# AXI4 Burst-Splitting Read Engine

This block turns a simple byte-oriented read request into AXI4 read traffic. A base address is loaded first. Each later request gives a byte offset from that base and a byte count. The engine adds the offset to the base and aligns the start down to the bus width. It then issues one or more INCR bursts on the read-address channel. Every data beat that comes back on the read-data channel is forwarded as a response packet. Each packet carries the data word, an error status, the number of bytes in that word that belong to the request, and a flag marking the final packet.

A burst is closed early whenever it would cross a 4 KB page, or when it would exceed the longest legal burst. The rest of the request continues in a new burst. Start and end addresses need not be aligned. Leading bytes before the start and trailing bytes past the end are excluded from the per-packet byte count. Only one request is in flight at a time, and bursts are issued one after another.

Top module: `axi_burst_reader`

## Requirements
- R1: The first read-address of a request is (base + offset) with its low log2(DATA_W/8) bits cleared. Every read-address is aligned to the bus width. The base is the value last accepted on the configuration input.
- R2: Every read-address carries burst type INCR (arBurst = 2'b01), arSize = log2(DATA_W/8) (2 for a 32-bit bus) and arId = 0. arLen equals the burst's beat count minus one.
- R3: No burst crosses a 4 KB address boundary. A request spanning a boundary is split there into consecutive bursts.
- R4: No burst exceeds 256 beats (arLen at most 255). Longer spans are split into bursts of 256 beats, followed by a shorter remainder.
- R5: Exactly one response packet is produced per bus-width word covered by the request, in address order. Its data equals the returned beat, and respLast is 1 only on the final packet.
- R6: The first packet's byte count excludes the bytes of its word that lie below base + offset.
- R7: The final packet's byte count excludes the bytes at or above base + offset + length, so the counts of a request sum to its length. No count exceeds DATA_W/8.
- R8: respStatus is 1 (error) on the packet of any beat returned with rResp = 2'b10 or 2'b11, and on every later packet of the same request. Otherwise it is 0. The flag clears when a new request is accepted.
- R9: A request with length 0 issues no read-address. It returns a single packet with byte count 0, respLast = 1, status 0 and data 0.
- R10: reqReady and cfgReady are 1 only while idle. reqReady falls in the cycle after a request is accepted and stays low until its final packet is taken. When cfgValid and reqValid are both high while idle, the configuration is taken first.
- R11: Once arValid is raised, it stays high with arAddr and arLen unchanged until arReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Base-address load request |
| cfgReady | output | 1 | Engine idle, base may be loaded |
| cfgBase | input | ADDR_W | New base address |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqOffset | input | ADDR_W | Byte offset from the base |
| reqLength | input | LEN_W | Byte count of the read |
| arValid | output | 1 | Read-address valid |
| arReady | input | 1 | Read-address accepted by the subordinate |
| arAddr | output | ADDR_W | Burst start address |
| arLen | output | 8 | Beats in burst minus one |
| arSize | output | 3 | Bytes per beat, log2 |
| arBurst | output | 2 | Burst type, always INCR |
| arId | output | ID_W | Transaction ID, always 0 |
| rValid | input | 1 | Read-data valid |
| rReady | output | 1 | Read-data accepted |
| rData | input | DATA_W | Read-data word |
| rResp | input | 2 | Read response code |
| respValid | output | 1 | Response packet valid |
| respReady | input | 1 | Response packet taken |
| respData | output | DATA_W | Packet data word |
| respStatus | output | 1 | 0 success, 1 error |
| respLength | output | log2(DATA_W/8)+1 | Valid bytes in this packet |
| respLast | output | 1 | Final packet of the request |

## Verification
A wrong beat counter shows up within one burst as a packet count different from the number of words spanned, or as respLast on the wrong packet. A wrong per-burst counter shows as an extra or missing read-address at the next split point. A bad page-offset or length limit gives an arLen that lands past a 4 KB edge or above 255. This is flagged on the same cycle that arValid rises. A stale error flag or stale address register leaks into the following request, so requests are run back to back with different bases, alignments and error positions.

// File: rtl/axi_rd_pkg.sv
package axi_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ZERO
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic reqLoad;
    logic burstIssue;
    logic beatTake;
    logic zeroPkt;
  } rdStrobe_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/axi_rd_ctrl.sv
module axi_rd_ctrl
  import axi_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgValid,
  output logic      cfgReady,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      reqIsZero,
  output logic      arValid,
  input  logic      arReady,
  input  logic      rValid,
  output logic      rReady,
  output logic      respValid,
  input  logic      respReady,
  output logic      respLast,
  input  logic      finalBeat,
  input  logic      burstEnd,
  output rdStrobe_t strobe
);

  rdState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    cfgReady  = 1'b0;
    reqReady  = 1'b0;
    arValid   = 1'b0;
    rReady    = 1'b0;
    respValid = 1'b0;
    respLast  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cfgReady = 1'b1;
        reqReady = !cfgValid;           // configuration wins a tie
        if (cfgValid) begin
          strobe.cfgLoad = 1'b1;
        end else if (reqValid) begin
          strobe.reqLoad = 1'b1;
          nextState = reqIsZero ? ST_ZERO : ST_ADDR;
        end
      end
      ST_ADDR: begin
        arValid = 1'b1;
        if (arReady) begin
          strobe.burstIssue = 1'b1;
          nextState = ST_DATA;
        end
      end
      ST_DATA: begin
        rReady    = respReady;          // beats pass straight through
        respValid = rValid;
        respLast  = finalBeat;
        if (rValid && respReady) begin
          strobe.beatTake = 1'b1;
          if (burstEnd) nextState = finalBeat ? ST_IDLE : ST_ADDR;
        end
      end
      ST_ZERO: begin
        respValid = 1'b1;
        respLast  = 1'b1;
        strobe.zeroPkt = 1'b1;
        if (respReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/axi_rd_datapath.sv
module axi_rd_datapath
  import axi_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 256,
  parameter int BOUNDARY  = 4096,
  localparam int BYTES    = DATA_W / 8,
  localparam int CNT_W    = $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLength,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  output logic              reqIsZero,
  output logic              finalBeat,
  output logic              burstEnd,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [DATA_W-1:0] respData,
  output logic              respStatus,
  output logic [CNT_W-1:0]  respLength
);

  localparam int SHIFT   = $clog2(BYTES);
  localparam int BEAT_W  = LEN_W + 1;
  localparam int BURST_W = $clog2(MAX_BEATS) + 1;
  localparam int PAGE_W  = $clog2(BOUNDARY);
  localparam int BND_W   = PAGE_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BYTES - 1);

  logic [ADDR_W-1:0]  baseReg, startAddr, endAddr, beatAddr;
  logic [BEAT_W-1:0]  beatsLeft;
  logic [BURST_W-1:0] burstLeft;
  logic               errSticky;

  logic [ADDR_W-1:0]  reqStart, reqEnd, reqSpan, beatEnd, hiAddr, loAddr;
  logic [BEAT_W-1:0]  reqBeats, beatLimit;
  logic [BND_W-1:0]   pageBeats;
  logic [BURST_W-1:0] burstBeats;
  logic               rErr;

  // Request address arithmetic
  always_comb begin
    reqStart = baseReg + reqOffset;
    reqEnd   = reqStart + ADDR_W'(reqLength);
    reqSpan  = reqEnd - (reqStart & ALIGN_MASK);
    reqBeats = BEAT_W'((reqSpan + ADDR_W'(BYTES - 1)) >> SHIFT);
  end

  // Burst size: smallest of words left, words to page edge, burst cap
  always_comb begin
    pageBeats = (BND_W'(BOUNDARY) - {1'b0, beatAddr[PAGE_W-1:0]}) >> SHIFT;
    beatLimit = beatsLeft;
    if (BEAT_W'(pageBeats) < beatLimit) beatLimit = BEAT_W'(pageBeats);
    if (BEAT_W'(MAX_BEATS) < beatLimit) beatLimit = BEAT_W'(MAX_BEATS);
    burstBeats = BURST_W'(beatLimit);
    arLen      = 8'(burstBeats - BURST_W'(1));
    arAddr     = beatAddr;
  end

  // Valid-byte window of the current word
  always_comb begin
    beatEnd    = beatAddr + ADDR_W'(BYTES);
    hiAddr     = (beatEnd > endAddr) ? endAddr : beatEnd;
    loAddr     = (beatAddr < startAddr) ? startAddr : beatAddr;
    rErr       = (rResp == 2'b10) || (rResp == 2'b11);
    respLength = strobe.zeroPkt ? '0 : CNT_W'(hiAddr - loAddr);
    respData   = strobe.zeroPkt ? '0 : rData;
    respStatus = strobe.zeroPkt ? 1'b0 : (errSticky | rErr);
    reqIsZero  = (reqLength == '0);
    finalBeat  = (beatsLeft == BEAT_W'(1));
    burstEnd   = (burstLeft == BURST_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      startAddr <= '0;
      endAddr   <= '0;
      beatAddr  <= '0;
      beatsLeft <= '0;
      burstLeft <= '0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.cfgLoad) baseReg <= cfgBase;
      if (strobe.reqLoad) begin
        startAddr <= reqStart;
        endAddr   <= reqEnd;
        beatAddr  <= reqStart & ALIGN_MASK;
        beatsLeft <= reqBeats;
        errSticky <= 1'b0;
      end
      if (strobe.burstIssue) burstLeft <= burstBeats;
      if (strobe.beatTake) begin
        beatAddr  <= beatEnd;
        beatsLeft <= beatsLeft - BEAT_W'(1);
        burstLeft <= burstLeft - BURST_W'(1);
        errSticky <= errSticky | rErr;
      end
    end
  end

endmodule

// File: rtl/axi_burst_reader.sv
module axi_burst_reader
  import axi_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int ID_W      = 4,
  parameter int MAX_BEATS = 256,
  parameter int BOUNDARY  = 4096,
  localparam int CNT_W    = $clog2(DATA_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  output logic              cfgReady,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLength,
  output logic              arValid,
  input  logic              arReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic [ID_W-1:0]   arId,
  input  logic              rValid,
  output logic              rReady,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  output logic              respValid,
  input  logic              respReady,
  output logic [DATA_W-1:0] respData,
  output logic              respStatus,
  output logic [CNT_W-1:0]  respLength,
  output logic              respLast
);

  rdStrobe_t strobe;
  logic reqIsZero, finalBeat, burstEnd;

  assign arSize  = 3'($clog2(DATA_W / 8));
  assign arBurst = BURST_INCR;
  assign arId    = '0;

  axi_rd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgReady(cfgReady),
    .reqValid(reqValid), .reqReady(reqReady), .reqIsZero(reqIsZero),
    .arValid(arValid), .arReady(arReady),
    .rValid(rValid), .rReady(rReady),
    .respValid(respValid), .respReady(respReady), .respLast(respLast),
    .finalBeat(finalBeat), .burstEnd(burstEnd), .strobe(strobe)
  );

  axi_rd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .MAX_BEATS(MAX_BEATS), .BOUNDARY(BOUNDARY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgBase(cfgBase), .reqOffset(reqOffset), .reqLength(reqLength),
    .rData(rData), .rResp(rResp),
    .reqIsZero(reqIsZero), .finalBeat(finalBeat), .burstEnd(burstEnd),
    .arAddr(arAddr), .arLen(arLen),
    .respData(respData), .respStatus(respStatus), .respLength(respLength)
  );

endmodule

// File: rtl/axi_burst_reader_chk.sv
module axi_burst_reader_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MAX_BEATS = 256,
  parameter int BOUNDARY  = 4096,
  localparam int BYTES    = DATA_W / 8,
  localparam int CNT_W    = $clog2(BYTES) + 1,
  localparam int PAGE_W   = $clog2(BOUNDARY)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              arValid,
  input logic              arReady,
  input logic [ADDR_W-1:0] arAddr,
  input logic [7:0]        arLen,
  input logic [2:0]        arSize,
  input logic [1:0]        arBurst,
  input logic [ID_W-1:0]   arId,
  input logic              respValid,
  input logic [CNT_W-1:0]  respLength
);

  p_ar_attr_r2: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (arBurst == 2'b01) && (arSize == 3'($clog2(BYTES))) && (arId == '0));

  p_ar_aligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> ((arAddr & ADDR_W'(BYTES - 1)) == '0));

  p_no_page_cross_r3: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (int'(arAddr[PAGE_W-1:0]) + (int'(arLen) + 1) * BYTES) <= BOUNDARY);

  p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (int'(arLen) + 1) <= MAX_BEATS);

  p_ar_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr) && $stable(arLen));

  p_one_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> int'(respLength) <= BYTES);

endmodule

bind axi_burst_reader axi_burst_reader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
  .MAX_BEATS(MAX_BEATS), .BOUNDARY(BOUNDARY)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arLen(arLen),
  .arSize(arSize), .arBurst(arBurst), .arId(arId),
  .respValid(respValid), .respLength(respLength)
);

// File: tb/axi_burst_reader_tb.sv
module axi_burst_reader_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgValid, cfgReady, reqValid, reqReady;
  logic [31:0] cfgBase, reqOffset;
  logic [15:0] reqLength;
  logic        arValid, arReady;
  logic [31:0] arAddr;
  logic [7:0]  arLen;
  logic [2:0]  arSize;
  logic [1:0]  arBurst;
  logic [3:0]  arId;
  logic        rValid, rReady;
  logic [31:0] rData;
  logic [1:0]  rResp;
  logic        respValid, respReady, respStatus, respLast;
  logic [31:0] respData;
  logic [2:0]  respLength;

  always #(CLK_P / 2) clk = ~clk;

  axi_burst_reader u_dut (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgBase(cfgBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqOffset(reqOffset), .reqLength(reqLength),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arLen(arLen),
    .arSize(arSize), .arBurst(arBurst), .arId(arId),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .respValid(respValid), .respReady(respReady), .respData(respData),
    .respStatus(respStatus), .respLength(respLength), .respLast(respLast)
  );

  int nChecks = 0;
  int nErrors = 0;

  // Bus logs
  logic [31:0] arLogAddr [0:63];
  logic [7:0]  arLogLen  [0:63];
  logic [31:0] pktData   [0:511];
  int          pktLen    [0:511];
  logic        pktStat   [0:511];
  logic        pktLast   [0:511];
  int arCount = 0;
  int pktCount = 0;
  int sIdx = 0;
  int sBeat = 0;
  int arHold = 0;
  int cyc = 0;
  bit respStall = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  bit hsR = 0;

  function automatic logic [31:0] beatWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Subordinate model and response collector: drive at negedge, sample 1 later
  initial begin
    arReady = 0; rValid = 0; rData = 0; rResp = 0; respReady = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (hsR) begin
        sBeat++;
        if (sBeat > int'(arLogLen[sIdx])) begin sIdx++; sBeat = 0; end
      end
      if (arHold > 0 && arValid) begin arReady = 0; arHold--; end
      else arReady = 1;
      respReady = respStall ? cyc[0] : 1'b1;
      if (sIdx < arCount) begin
        logic [31:0] a;
        a = arLogAddr[sIdx] + 32'(sBeat * 4);
        rValid = 1; rData = beatWord(a);
        rResp = (a == errAddr) ? 2'b10 : 2'b00;
      end else begin
        rValid = 0; rResp = 0;
      end
      #1;
      if (arValid && arReady) begin
        arLogAddr[arCount] = arAddr; arLogLen[arCount] = arLen; arCount++;
      end
      hsR = rValid && rReady;
      if (respValid && respReady) begin
        pktData[pktCount] = respData; pktLen[pktCount] = int'(respLength);
        pktStat[pktCount] = respStatus; pktLast[pktCount] = respLast;
        pktCount++;
      end
    end
  end

  task automatic doCfg(input logic [31:0] b);
    @(negedge clk); cfgValid = 1; cfgBase = b;
    @(negedge clk); cfgValid = 0;
  endtask

  task automatic startReq(input logic [31:0] off, input int len);
    @(negedge clk);
    reqValid = 1; reqOffset = off; reqLength = 16'(len);
    #2;
    while (!reqReady) begin @(negedge clk); #2; end
    @(negedge clk); reqValid = 0;
    #2;
    chk("R10", "reqReady after accept", int'(reqReady), 0);
    chk("R10", "cfgReady while busy", int'(cfgReady), 0);
  endtask

  task automatic waitDone(input int pS);
    while (!(pktCount > pS && pktLast[pktCount-1])) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Expected bursts and packets worked out from the requirements
  task automatic checkRead(input string tag, input logic [31:0] start, input int len,
                           input int arS, input int pS);
    logic [31:0] al, e, a, lo, hi;
    int nb, rem, n, k;
    bit err;
    al = start & ~32'h3; e = start + 32'(len);
    nb = int'((e - al + 32'd3) >> 2);
    a = al; rem = nb; k = 0;
    while (rem > 0) begin
      n = rem;
      if (n > 256) n = 256;
      if (n > (4096 - int'(a % 4096)) / 4) n = (4096 - int'(a % 4096)) / 4;
      chk({tag, " R1/R3"}, "ar addr", int'(arLogAddr[arS+k]), int'(a));
      chk({tag, " R2/R4"}, "ar len", int'(arLogLen[arS+k]), n - 1);
      a = a + 32'(n * 4); rem -= n; k++;
    end
    chk({tag, " R3"}, "ar count", arCount - arS, k);
    chk({tag, " R5"}, "packet count", pktCount - pS, nb);
    err = 0;
    for (int i = 0; i < nb; i++) begin
      a = al + 32'(i * 4);
      lo = (a < start) ? start : a;
      hi = (a + 32'd4 > e) ? e : a + 32'd4;
      if (a == errAddr) err = 1;
      chk({tag, " R5"}, "data", int'(pktData[pS+i]), int'(beatWord(a)));
      chk({tag, " R6/R7"}, "byte count", pktLen[pS+i], int'(hi - lo));
      chk({tag, " R5"}, "last", int'(pktLast[pS+i]), (i == nb - 1) ? 1 : 0);
      chk({tag, " R8"}, "status", int'(pktStat[pS+i]), int'(err));
    end
  endtask

  task automatic runRead(input string tag, input logic [31:0] base, input logic [31:0] off,
                         input int len);
    int arS, pS;
    arS = arCount; pS = pktCount;
    startReq(off, len);
    waitDone(pS);
    checkRead(tag, base + off, len, arS, pS);
  endtask

  task automatic testAligned();      // R1 R2 R5
    doCfg(32'h1000);
    runRead("aligned", 32'h1000, 32'h10, 16);
    chk("R2", "arSize", int'(arSize), 2);
    chk("R2", "arBurst", int'(arBurst), 1);
    chk("R2", "arId", int'(arId), 0);
  endtask

  task automatic testUnaligned();    // R6 R7
    runRead("unaligned", 32'h1000, 32'h13, 10);
  endtask

  task automatic testPageCross();    // R3 R11
    int arS, pS;
    logic [31:0] held;
    arS = arCount; pS = pktCount;
    arHold = 4;
    startReq(32'hFF8, 16);
    chk("R11", "arValid raised", int'(arValid), 1);
    held = arAddr;
    repeat (2) begin
      @(negedge clk); #2;
      chk("R11", "arValid held", int'(arValid), 1);
      chk("R11", "arAddr held", int'(arAddr), int'(held));
    end
    waitDone(pS);
    checkRead("page", 32'h1FF8, 16, arS, pS);
  endtask

  task automatic testLong();         // R4 R7
    int sum, pS;
    doCfg(32'h10000);
    respStall = 1;
    pS = pktCount;
    runRead("long", 32'h10000, 32'h0, 1100);
    respStall = 0;
    sum = 0;
    for (int i = pS; i < pktCount; i++) sum += pktLen[i];
    chk("R7", "byte sum", sum, 1100);
  endtask

  task automatic testError();        // R8
    doCfg(32'h1000);
    errAddr = 32'h1FF4;
    runRead("error", 32'h1000, 32'hFF0, 32);
    errAddr = 32'hFFFF_FFFF;
    runRead("after-error", 32'h1000, 32'h20, 8);
  endtask

  task automatic testZero();         // R9
    int arS, pS;
    arS = arCount; pS = pktCount;
    startReq(32'h40, 0);
    waitDone(pS);
    chk("R9", "no address issued", arCount - arS, 0);
    chk("R9", "one packet", pktCount - pS, 1);
    chk("R9", "length", pktLen[pS], 0);
    chk("R9", "last", int'(pktLast[pS]), 1);
    chk("R9", "status", int'(pktStat[pS]), 0);
    chk("R9", "data", int'(pktData[pS]), 0);
  endtask

  task automatic testCfgPriority();  // R10 R1
    int arS, pS;
    arS = arCount; pS = pktCount;
    @(negedge clk);
    cfgValid = 1; cfgBase = 32'h3000;
    reqValid = 1; reqOffset = 32'h4; reqLength = 16'd4;
    #2;
    chk("R10", "reqReady during config", int'(reqReady), 0);
    @(negedge clk); cfgValid = 0;
    #2;
    chk("R10", "reqReady after config", int'(reqReady), 1);
    @(negedge clk); reqValid = 0;
    waitDone(pS);
    checkRead("cfg-first", 32'h3004, 4, arS, pS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    rstN = 0; cfgValid = 0; cfgBase = 0; reqValid = 0; reqOffset = 0; reqLength = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #2;
    chk("R10", "reset reqReady", int'(reqReady), 1);
    chk("R10", "reset cfgReady", int'(cfgReady), 1);
    chk("R11", "reset arValid", int'(arValid), 0);
    chk("R5", "reset respValid", int'(respValid), 0);
    testAligned();
    testUnaligned();
    testPageCross();
    testLong();
    testError();
    testZero();
    testCfgPriority();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule